// File: doc/BRIEF.md
# Multi-Lane Aggregated GHASH Engine

This block produces a GHASH authentication tag over a message made of 128-bit blocks. The message is spread over several interleaved accumulators called lanes. Block i of the message goes to lane i mod n. Each lane first multiplies its running value by the same key power H^n and then adds its new block. H^n is read from one broadcast register that all lanes share; no lane keeps its own copy. When the last block has been absorbed, each lane is multiplied by a power of H that depends on its position and on how full the last round was. The products are XORed to form the tag, and this tag equals the one a serial GHASH would produce.

The caller supplies the hash key H, because deriving H from a cipher key is not part of this block. The caller also supplies any length block, as an ordinary message block. A start pulse captures H and the lane count. The engine then builds H^2 through H^n with a single shared bit-serial multiplier, loads H^n into the broadcast register, and after that accepts blocks over a valid/ready stream. Every multiplication takes 128 cycles, so `s_ready` is raised only while the multiplier is idle.

Top module: `ghash_lanes`

## Requirements
- R1: While reset is held and after it is released, `s_ready` and `tag_valid` are 0 and `tag` is all zeros.
- R2: Field elements use GCM bit-reflected order: bit 127 of a 128-bit word is the coefficient of x^0 and bit 0 is the coefficient of x^127. Reduction is modulo x^128 + x^7 + x^2 + x + 1. With one lane, the tag equals serial GHASH Y_i = (Y_{i-1} xor X_i)·H, starting from Y_0 = 0.
- R3: On an accepted start, `lanes` is captured as the lane count n. A value of 0 is used as 1, and a value above MAX_LANES is used as MAX_LANES.
- R4: After the clock edge that accepts start, `s_ready` stays low for exactly 1 + 129·(n−1) cycles while H^2..H^n are computed. It then rises with H^n held in the broadcast register.
- R5: When the message length is a multiple of n, with block i sent to lane i mod n and every lane multiplying by the broadcast H^n, the tag equals serial GHASH of the message.
- R6: When the message length is not a multiple of n, including messages shorter than n, the tag still equals serial GHASH. Empty lanes contribute zero and the fold powers are shifted to match.
- R7: A block is accepted on a clock edge where `s_valid` and `s_ready` are both high. In the cycle after any accepted block, `s_ready` is low. After the block marked `s_last`, `s_ready` stays low until the next accepted start.
- R8: `tag_valid` is high for exactly one cycle per message. `tag` changes only in the cycle in which `tag_valid` is high, and it holds its value until the next message completes.
- R9: `start` is accepted only when the engine is idle, meaning after reset or after `tag_valid`. A start pulse during a message changes neither the key, the lane count nor the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new message; captures `hkey` and `lanes` |
| hkey | input | 128 | Hash key H in bit-reflected order |
| lanes | input | $clog2(MAX_LANES+1) (3) | Requested lane count |
| s_valid | input | 1 | Message block present |
| s_data | input | 128 | Message block |
| s_last | input | 1 | Marks the final block of the message |
| s_ready | output | 1 | Engine can take a block this cycle |
| tag | output | 128 | Computed tag, held until the next completion |
| tag_valid | output | 1 | One-cycle pulse when `tag` is updated |

## Verification
The most error-prone part is the final fold for lengths that are not a multiple of n, so the bench checks n = 2, 3 and 4 with lengths one short of, one over, and below a full round. A wrong exponent choice would give the correct tag only for full rounds. It would also give a wrong tag for a message shorter than the lane count. The bench counts the cycles that `s_ready` stays low after start. An engine that skipped or repeated a power computation, or that mishandled the clamping of a lane count of 0 or 7, would show the wrong count and also the wrong tag. A start pulse injected mid-message, with a different key, checks that the running hash cannot be corrupted.

// File: rtl/ghash_lanes.sv
module ghash_lanes #(
  parameter int MAX_LANES = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [127:0]                     hkey,
  input  logic [$clog2(MAX_LANES+1)-1:0]   lanes,
  input  logic                             s_valid,
  input  logic [127:0]                     s_data,
  input  logic                             s_last,
  output logic                             s_ready,
  output logic [127:0]                     tag,
  output logic                             tag_valid
);
  localparam int CW = $clog2(MAX_LANES + 1);
  localparam int IW = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1;
  localparam logic [127:0] RPOLY = {8'he1, 120'd0};

  typedef enum logic [2:0] {S_IDLE, S_POW, S_RUN, S_MUL, S_FOLD} st_t;
  typedef enum logic [1:0] {J_POW, J_BLK, J_FOLD} job_t;

  st_t          st;
  job_t         job;
  logic [CW-1:0] n, k, fj, lanes_c;
  logic [IW-1:0] nl, pidx;
  logic [127:0] pw  [MAX_LANES];
  logic [127:0] acc [MAX_LANES];
  logic [127:0] hn, xin, ma, mv, mz, fsum, tag_q;
  logic [6:0]   mcnt;
  logic         lst, tv;
  logic [CW:0]  ex;

  wire [127:0] zn = mz ^ (ma[127] ? mv : 128'd0);
  wire [127:0] vn = mv[0] ? ((mv >> 1) ^ RPOLY) : (mv >> 1);
  wire [CW-1:0] nlx = CW'(nl);

  always_comb begin
    if (lanes == '0)                    lanes_c = CW'(1);
    else if (lanes > CW'(MAX_LANES))    lanes_c = CW'(MAX_LANES);
    else                                lanes_c = lanes;
  end

  always_comb begin
    ex = {1'b0, nlx} + {1'b0, n} - {1'b0, fj};
    if (ex >= {1'b0, n}) ex = ex - {1'b0, n};
    if (ex == '0)        ex = {1'b0, n};
    pidx = IW'(ex - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      job   <= J_POW;
      n     <= CW'(1);
      k     <= '0;
      fj    <= '0;
      nl    <= '0;
      hn    <= '0;
      xin   <= '0;
      ma    <= '0;
      mv    <= '0;
      mz    <= '0;
      fsum  <= '0;
      tag_q <= '0;
      mcnt  <= '0;
      lst   <= 1'b0;
      tv    <= 1'b0;
      for (int i = 0; i < MAX_LANES; i++) begin
        pw[i]  <= '0;
        acc[i] <= '0;
      end
    end else begin
      tv <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          n     <= lanes_c;
          pw[0] <= hkey;
          for (int i = 0; i < MAX_LANES; i++) acc[i] <= '0;
          nl    <= '0;
          k     <= CW'(1);
          st    <= S_POW;
        end
        S_POW: begin
          if (k == n) begin
            hn <= pw[IW'(n - 1'b1)];
            st <= S_RUN;
          end else begin
            ma   <= pw[IW'(k - 1'b1)];
            mv   <= pw[0];
            mz   <= '0;
            mcnt <= '0;
            job  <= J_POW;
            st   <= S_MUL;
          end
        end
        S_RUN: if (s_valid) begin
          ma   <= acc[nl];
          mv   <= hn;
          mz   <= '0;
          mcnt <= '0;
          xin  <= s_data;
          lst  <= s_last;
          job  <= J_BLK;
          st   <= S_MUL;
        end
        S_MUL: begin
          ma   <= ma << 1;
          mv   <= vn;
          mz   <= zn;
          mcnt <= mcnt + 7'd1;
          if (mcnt == 7'd127) begin
            case (job)
              J_POW: begin
                pw[IW'(k)] <= zn;
                k          <= k + 1'b1;
                st         <= S_POW;
              end
              J_BLK: begin
                acc[nl] <= zn ^ xin;
                nl      <= (nlx + 1'b1 == n) ? '0 : nl + 1'b1;
                if (lst) begin
                  fj   <= '0;
                  fsum <= '0;
                  st   <= S_FOLD;
                end else begin
                  st <= S_RUN;
                end
              end
              default: begin
                fsum <= fsum ^ zn;
                fj   <= fj + 1'b1;
                st   <= S_FOLD;
              end
            endcase
          end
        end
        S_FOLD: begin
          if (fj == n) begin
            tag_q <= fsum;
            tv    <= 1'b1;
            st    <= S_IDLE;
          end else begin
            ma   <= acc[IW'(fj)];
            mv   <= pw[pidx];
            mz   <= '0;
            mcnt <= '0;
            job  <= J_FOLD;
            st   <= S_MUL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign s_ready   = (st == S_RUN);
  assign tag       = tag_q;
  assign tag_valid = tv;

  AST_ONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) tag_valid |=> !tag_valid); // R8
  AST_TAG_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !$stable(tag) |-> tag_valid); // R8
  AST_BLOCK_GAP:   assert property (@(posedge clk) disable iff (!rst_n) (s_valid && s_ready) |=> !s_ready); // R7
  AST_LAST_CLOSE:  assert property (@(posedge clk) disable iff (!rst_n) (s_valid && s_ready && s_last) |=> (st == S_MUL && lst)); // R7
  AST_START_GATE:  assert property (@(posedge clk) disable iff (!rst_n) (start && st == S_IDLE) |=> !s_ready); // R4
  AST_LANE_COUNT:  assert property (@(posedge clk) disable iff (!rst_n) (st != S_IDLE) |-> (n >= CW'(1) && n <= CW'(MAX_LANES))); // R3
  AST_LANE_INDEX:  assert property (@(posedge clk) disable iff (!rst_n) (st != S_IDLE) |-> (nlx < n)); // R5
  AST_BCAST_FIXED: assert property (@(posedge clk) disable iff (!rst_n) (st == S_MUL && job == J_BLK) |-> $stable(hn)); // R5
endmodule

// File: tb/tb_ghash_lanes.sv
`timescale 1ns/1ps
module tb_ghash_lanes;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] hkey = '0;
  logic [2:0]   lanes = 3'd1;
  logic         s_valid = 1'b0;
  logic [127:0] s_data = '0;
  logic         s_last = 1'b0;
  logic         s_ready, tag_valid;
  logic [127:0] tag;

  int errors = 0;
  int checks = 0;
  logic [127:0] msg [16];
  logic [127:0] prev_tag = '0;
  logic         prev_tv = 1'b0;

  always #10 clk = ~clk;

  ghash_lanes #(.MAX_LANES(4)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hkey(hkey), .lanes(lanes),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .tag(tag), .tag_valid(tag_valid)
  );

  function automatic logic [127:0] gmul(input logic [127:0] x, input logic [127:0] y);
    logic [127:0] z = '0;
    logic [127:0] v = y;
    for (int i = 0; i < 128; i++) begin
      if (x[127 - i]) z = z ^ v;
      v = v[0] ? ((v >> 1) ^ {8'he1, 120'd0}) : (v >> 1);
    end
    return z;
  endfunction

  function automatic logic [127:0] serial_ghash(input logic [127:0] h, input int len);
    logic [127:0] y = '0;
    for (int i = 0; i < len; i++) y = gmul(y ^ msg[i], h);
    return y;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R8 monitored on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(tag_valid && prev_tv), "R8", {127'd0, tag_valid}, 128'd0);
      chk(tag_valid || (tag == prev_tag), "R8", tag, prev_tag);
    end
    prev_tag = tag;
    prev_tv  = tag_valid;
  end

  task automatic run_msg(input logic [2:0] lin, input int neff, input int len,
                         input string req, input bit inject);
    logic [127:0] h;
    logic [127:0] exp;
    int lat;
    int guard;
    h = {$urandom, $urandom, $urandom, $urandom};
    for (int i = 0; i < len; i++) msg[i] = {$urandom, $urandom, $urandom, $urandom};
    exp = serial_ghash(h, len);
    @(negedge clk);
    start = 1'b1; hkey = h; lanes = lin;
    @(negedge clk);
    start = 1'b0; hkey = ~h; lanes = 3'd1;
    lat = 0;
    while (!s_ready && lat < 2000) begin
      lat++;
      @(negedge clk);
    end
    chk(lat == 1 + 129 * (neff - 1), (lin == 3'd0 || lin > 3'd4) ? "R3/R4" : "R4",
        128'(lat), 128'(1 + 129 * (neff - 1)));
    for (int b = 0; b < len; b++) begin
      s_valid = 1'b1; s_data = msg[b]; s_last = (b == len - 1);
      guard = 0;
      while (!s_ready && guard < 2000) begin
        guard++;
        @(negedge clk);
      end
      @(negedge clk);
      s_valid = 1'b0; s_last = 1'b0; s_data = '0;
      chk(!s_ready, "R7", {127'd0, s_ready}, 128'd0);
      if (inject && b == 0) begin
        start = 1'b1; hkey = {$urandom, $urandom, $urandom, $urandom}; lanes = 3'd1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    guard = 0;
    while (!tag_valid && guard < 5000) begin
      guard++;
      @(negedge clk);
    end
    chk(tag_valid && tag == exp, req, tag, exp);
    @(negedge clk);
    chk(tag == exp, "R8", tag, exp);
    chk(!s_ready, "R7", {127'd0, s_ready}, 128'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!s_ready && !tag_valid && tag == '0, "R1", tag, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!s_ready && !tag_valid && tag == '0, "R1", {126'd0, s_ready, tag_valid}, 128'd0);
    run_msg(3'd1, 1, 1, "R2", 1'b0);
    run_msg(3'd1, 1, 3, "R2", 1'b0);
    run_msg(3'd2, 2, 2, "R5", 1'b0);
    run_msg(3'd2, 2, 4, "R5", 1'b0);
    run_msg(3'd4, 4, 4, "R5", 1'b0);
    run_msg(3'd4, 4, 8, "R5", 1'b0);
    run_msg(3'd2, 2, 3, "R6", 1'b0);
    run_msg(3'd2, 2, 1, "R6", 1'b0);
    run_msg(3'd4, 4, 5, "R6", 1'b0);
    run_msg(3'd4, 4, 7, "R6", 1'b0);
    run_msg(3'd4, 4, 2, "R6", 1'b0);
    run_msg(3'd3, 3, 5, "R6", 1'b0);
    run_msg(3'd0, 1, 2, "R3", 1'b0);
    run_msg(3'd7, 4, 6, "R3", 1'b0);
    run_msg(3'd2, 2, 5, "R9", 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule